// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block sits behind a pair of window comparators that watch a three-level PWM control line. One comparator output says the line is above the upper window threshold, the other says it is below the lower one. Both arrive asynchronously. The decoder synchronizes them and turns the result into one of three one-hot commands for a downstream gate-drive stage: drive the high side, drive the low side, or switch both sides off.

A firm high or low level takes effect as soon as it has passed the synchronizer, with no further delay. A mid level is treated differently. It must stay inside the window for a programmable number of consecutive samples before it becomes the off command. This lets ordinary edges pass through the window without disturbing the output. It also lets a controller park the line at mid level, or leave it open so it floats into the window, to shed a phase. When both comparators claim to be active at once, the state is illegal and is taken as in-window. A separate flag shows, without the hold-off, whether the synchronized input is currently in the window.

Top module: `pwm3_decoder`

## Requirements
- R1: Exactly one of cmdHigh, cmdLow and cmdOff is 1 in every cycle. The encoding is one-hot: cmdHigh means drive the high side, cmdLow means drive the low side, cmdOff means both sides off.
- R2: While rstN is low, and after it is released, cmdOff is 1 until the first valid high or low sample has been decoded.
- R3: aboveUpper=1 with belowLower=0 is a high sample. When applied between clock edges, it sets cmdHigh after the third following rising edge: two synchronizer edges plus one command-register edge.
- R4: belowLower=1 with aboveUpper=0 is a low sample. It sets cmdLow with the same three-edge latency as R3.
- R5: A window sample is one where neither input is asserted. HOLD_CYCLES consecutive synchronized window samples make cmdOff 1. It appears HOLD_CYCLES+2 rising edges after the input enters the window.
- R6: A window visit shorter than HOLD_CYCLES synchronized samples leaves the previous command unchanged.
- R7: Leaving the window toward high or low, including leaving from cmdOff, is acted on with the R3/R4 latency. No hold-off applies.
- R8: Both inputs asserted together is an illegal state. It is decoded as a window sample and counts toward the hold-off like any other window sample.
- R9: inWindow is 1 exactly when the synchronized sample is a window sample. It follows an input change two rising edges later.
- R10: The hold-off count restarts whenever a high or low sample intervenes. A window–high–window sequence needs a full fresh HOLD_CYCLES run before cmdOff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aboveUpper | input | 1 | Asynchronous comparator output: input above upper threshold |
| belowLower | input | 1 | Asynchronous comparator output: input below lower threshold |
| cmdHigh | output | 1 | Command: drive high side |
| cmdLow | output | 1 | Command: drive low side |
| cmdOff | output | 1 | Command: both sides off |
| inWindow | output | 1 | Synchronized input currently lies in the tri-state window |

## Verification
Two functions can meet in the same cycle: the hold-off counter expiring, and a window exit toward high or low. The stimulus provokes this by holding the input in the window for exactly HOLD_CYCLES-1 samples and then for exactly HOLD_CYCLES samples, with an exit on the very next sample in both cases. It also uses random run lengths clustered around the hold-off boundary. The outcome is judged against a cycle model in the bench built from the requirements. The shorter run must leave the earlier command in place. The exact-length run must produce one cycle of cmdOff, and the following sample must still be obeyed at once.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  // Decoded class of one synchronized comparator sample
  typedef enum logic [1:0] {
    LVL_MID  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_LOW  = 2'd2
  } levelE;

  // Command held by the control path
  typedef enum logic [1:0] {
    CMD_OFF  = 2'd0,
    CMD_HIGH = 2'd1,
    CMD_LOW  = 2'd2
  } cmdE;

  // Strobes from control to the hold-off datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } holdCtrlT;

endpackage

// File: rtl/pwm3_sync.sv
module pwm3_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pwm3_datapath.sv
module pwm3_datapath
  import pwm3_pkg::*;
#(
  parameter int HOLD_CYCLES = 18
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     aboveQ,
  input  logic     belowQ,
  input  holdCtrlT ctrl,
  output levelE    level,
  output logic     holdDone
);

  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] midCnt;

  // Illegal both-asserted state falls through to the window class
  always_comb begin
    if (aboveQ && !belowQ)      level = LVL_HIGH;
    else if (belowQ && !aboveQ) level = LVL_LOW;
    else                        level = LVL_MID;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             midCnt <= '0;
    else if (ctrl.cntClear) midCnt <= '0;
    else if (ctrl.cntStep)  midCnt <= midCnt + 1'b1;
  end

  assign holdDone = (level == LVL_MID) && (midCnt == LAST);

endmodule

// File: rtl/pwm3_control.sv
module pwm3_control
  import pwm3_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  levelE    level,
  input  logic     holdDone,
  output holdCtrlT ctrl,
  output logic     cmdHigh,
  output logic     cmdLow,
  output logic     cmdOff
);

  cmdE state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (level)
      LVL_HIGH: stateNxt = CMD_HIGH;
      LVL_LOW:  stateNxt = CMD_LOW;
      default:  if (holdDone) stateNxt = CMD_OFF;
    endcase
  end

  always_comb begin
    ctrl.cntClear = (level != LVL_MID);
    ctrl.cntStep  = (level == LVL_MID) && !holdDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CMD_OFF;
    else       state <= stateNxt;
  end

  assign cmdHigh = (state == CMD_HIGH);
  assign cmdLow  = (state == CMD_LOW);
  assign cmdOff  = (state == CMD_OFF);

endmodule

// File: rtl/pwm3_decoder.sv
module pwm3_decoder
  import pwm3_pkg::*;
#(
  parameter int HOLD_CYCLES = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic aboveUpper,
  input  logic belowLower,
  output logic cmdHigh,
  output logic cmdLow,
  output logic cmdOff,
  output logic inWindow
);

  logic [1:0] syncVec;
  logic       syncAbove;
  logic       syncBelow;
  levelE      level;
  logic       holdDone;
  holdCtrlT   ctrl;

  pwm3_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({aboveUpper, belowLower}),
    .syncOut (syncVec)
  );

  assign syncAbove = syncVec[1];
  assign syncBelow = syncVec[0];

  pwm3_datapath #(.HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .aboveQ   (syncAbove),
    .belowQ   (syncBelow),
    .ctrl     (ctrl),
    .level    (level),
    .holdDone (holdDone)
  );

  pwm3_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .level    (level),
    .holdDone (holdDone),
    .ctrl     (ctrl),
    .cmdHigh  (cmdHigh),
    .cmdLow   (cmdLow),
    .cmdOff   (cmdOff)
  );

  assign inWindow = (level == LVL_MID);

endmodule

// File: rtl/pwm3_decoder_chk.sv
module pwm3_decoder_chk #(
  parameter int HOLD_CYCLES = 18
) (
  input logic clk,
  input logic rstN,
  input logic syncAbove,
  input logic syncBelow,
  input logic cmdHigh,
  input logic cmdLow,
  input logic cmdOff,
  input logic inWindow
);

  localparam int RUN_W = $clog2(HOLD_CYCLES + 1) + 1;

  // Consecutive window samples seen before the current cycle, saturating
  logic [RUN_W-1:0] winRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               winRun <= '0;
    else if (!inWindow)                      winRun <= '0;
    else if (winRun < RUN_W'(HOLD_CYCLES))   winRun <= winRun + 1'b1;
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cmdHigh, cmdLow, cmdOff}) == 1);

  p_high_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (syncAbove && !syncBelow) |=> cmdHigh);

  p_low_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (syncBelow && !syncAbove) |=> cmdLow);

  p_hold_expire_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inWindow && winRun >= RUN_W'(HOLD_CYCLES - 1)) |=> cmdOff);

  p_short_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inWindow && winRun < RUN_W'(HOLD_CYCLES - 1)) |=> $stable({cmdHigh, cmdLow, cmdOff}));

  p_both_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    (syncAbove && syncBelow) |-> inWindow);

endmodule

bind pwm3_decoder pwm3_decoder_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .syncAbove (syncAbove),
  .syncBelow (syncBelow),
  .cmdHigh   (cmdHigh),
  .cmdLow    (cmdLow),
  .cmdOff    (cmdOff),
  .inWindow  (inWindow)
);

// File: tb/test_pwm3_decoder.sv
module test_pwm3_decoder;

  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveUpper = 1'b0;
  logic belowLower = 1'b0;
  logic cmdHigh, cmdLow, cmdOff, inWindow;

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R2";
  bit    done   = 1'b0;

  always #5 clk = ~clk;

  pwm3_decoder #(.HOLD_CYCLES(HOLD)) i_pwm3_decoder (
    .clk        (clk),
    .rstN       (rstN),
    .aboveUpper (aboveUpper),
    .belowLower (belowLower),
    .cmdHigh    (cmdHigh),
    .cmdLow     (cmdLow),
    .cmdOff     (cmdOff),
    .inWindow   (inWindow)
  );

  // Requirement model: two sync stages, then command register
  logic       m1a, m1b, m2a, m2b;
  logic [2:0] expCmd;   // {high, low, off}
  int         expRun;

  function automatic bit isWin(input logic a, input logic b);
    return !(a ^ b);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1a <= 0; m1b <= 0; m2a <= 0; m2b <= 0;
      expCmd <= 3'b001; expRun <= 0;
    end else begin
      m1a <= aboveUpper; m1b <= belowLower;
      m2a <= m1a; m2b <= m1b;
      if (m2a && !m2b) begin
        expCmd <= 3'b100; expRun <= 0;
      end else if (m2b && !m2a) begin
        expCmd <= 3'b010; expRun <= 0;
      end else begin
        if (expRun >= HOLD - 1) expCmd <= 3'b001;
        else expRun <= expRun + 1;
      end
    end
  end

  task automatic checkNow();
    logic [2:0] act;
    logic       expW;
    act  = {cmdHigh, cmdLow, cmdOff};
    expW = isWin(m2a, m2b);
    checks++;
    if (act !== expCmd || inWindow !== expW) begin
      fails++;
      $display("FAIL %s: cmd=%b win=%b expected cmd=%b win=%b at %0t",
               curReq, act, inWindow, expCmd, expW, $time);
    end
  endtask

  task automatic drive(input logic a, input logic b, input int n);
    aboveUpper = a;
    belowLower = b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkNow();
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R2: reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({cmdHigh, cmdLow, cmdOff} !== 3'b001) begin
      fails++;
      $display("FAIL R2: cmd=%b expected 001", {cmdHigh, cmdLow, cmdOff});
    end
    rstN = 1'b1;
    curReq = "R2"; drive(0, 0, HOLD + 3);
    curReq = "R3"; drive(1, 0, 5);
    curReq = "R4"; drive(0, 1, 5);
    curReq = "R6"; drive(0, 0, HOLD - 1);
    curReq = "R6"; drive(0, 1, 4);
    curReq = "R5"; drive(0, 0, HOLD);
    curReq = "R7"; drive(1, 0, 5);
    curReq = "R8"; drive(1, 1, HOLD + 3);
    curReq = "R7"; drive(0, 1, 5);
    curReq = "R10"; drive(0, 0, HOLD - 2);
    curReq = "R10"; drive(1, 0, 1);
    curReq = "R10"; drive(0, 0, HOLD + 3);
    curReq = "R9"; drive(1, 0, 1);
    curReq = "R9"; drive(0, 0, 1);
    curReq = "R9"; drive(0, 1, 4);
    // random runs around the hold-off boundary
    curReq = "R1";
    for (int k = 0; k < 400; k++) begin
      int sel;
      int len;
      sel = $urandom_range(0, 3);
      len = $urandom_range(1, HOLD + 3);
      drive(sel[1], sel[0], len);
    end
    drive(0, 0, HOLD + 4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule